// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is an SPI master that a processor core drives through a simple byte-wide register port. The core sets the mode, the bit order and the serial clock rate, then writes bytes into a short transmit queue. The controller takes the bytes from the queue one at a time and shifts each onto MOSI with SCLK, while it captures MISO. Each received byte goes into one of a bank of separately addressable receive registers, which the core reads back when it chooses.

The serial clock is the core clock divided by a power of two. All four combinations of clock polarity and phase are supported, and so are MSB-first and LSB-first order. Slave select is normally driven by the engine, which holds it low across a whole burst of queued bytes. A configuration bit can hand it to software instead. A sticky completion flag marks the end of each burst, and it can drive a level interrupt.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, ss_n is 1, sclk is 0 and irq is 0. The configuration register and the status register read as 0, and the divider register reads DIV_RESET (2 by default).
- R2: Reads decode as follows: 0x00 gives configuration, 0x01 gives status, 0x02 gives the divider, and 0x10+i gives receive register i. Every other address reads 0, and that includes the write-only transmit address 0x08.
- R3: Each byte takes exactly 16 SCLK transitions, and SCLK rests at configuration bit 2 (CPOL). With configuration bit 3 (CPHA) at 0, data is sampled on the leading edge and changed on the trailing edge. With CPHA at 1, data is changed on the leading edge and sampled on the trailing edge.
- R4: For a divider value d from 1 to DIV_CNT_W, the SCLK period is 2^d core cycles. A value of 0 acts as 1, and values above DIV_CNT_W act as DIV_CNT_W.
- R5: Configuration bit 4 at 0 sends and assembles bytes MSB first. At 1 it uses LSB first, in both directions.
- R6: In automatic mode (configuration bit 5 = 0), ss_n falls when the first queued byte is loaded. It stays low between back-to-back queued bytes. It rises one half SCLK period after the last byte's final edge, so a burst gives exactly one falling edge.
- R7: With configuration bit 5 = 1, ss_n equals configuration bit 6.
- R8: While configuration bit 0 is 1, the controller is disabled. SCLK rests at CPOL, ss_n is 1, any transfer is abandoned, and writes to 0x08 are ignored: no byte from them is ever sent.
- R9: The transmit queue holds TXQ_DEPTH (8) bytes, and a write to a full queue is dropped. Status bit 2 is 1 while at least TXQ_DEPTH/2 bytes are queued.
- R10: Received bytes fill receive registers 0, 1, 2 and so on in order. The index wraps after the last register and returns to 0 at the start of every burst.
- R11: Status bit 1 is 1 while a transfer is in progress. Status bit 0 is set when a burst ends. Writing status with bit 0 = 1 clears it, and writing 0 leaves it unchanged.
- R12: irq equals configuration bit 1 AND status bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt level |

## Verification
Some behaviours are checked on every cycle by the assertions. SCLK must return to its rest level after the sixteenth edge of a byte, and every engine tick must toggle SCLK. In automatic mode, slave select must stay low whenever SCLK moves. The queue occupancy must stay bounded, a write to a full queue must change nothing, a write while disabled must leave the queue untouched, and the write-one-to-clear of the completion flag must take effect. Other behaviours can only be shown by the bench scenarios, through a bench slave that samples MOSI and drives MISO. These are the bit order in both directions, the landing and wrap-around of received bytes, the exact SCLK period for a given divider value, the half-full threshold and the effect of the interrupt enable.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

   localparam logic [7:0] ADDR_CFG  = 8'h00;
   localparam logic [7:0] ADDR_STAT = 8'h01;
   localparam logic [7:0] ADDR_DIV  = 8'h02;
   localparam logic [7:0] ADDR_TXQ  = 8'h08;
   localparam logic [7:0] ADDR_RXB  = 8'h10;

   localparam int CFG_OFF  = 0;
   localparam int CFG_IEN  = 1;
   localparam int CFG_CPOL = 2;
   localparam int CFG_CPHA = 3;
   localparam int CFG_LSB  = 4;
   localparam int CFG_MAN  = 5;
   localparam int CFG_SSV  = 6;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_SHIFT = 2'd1,
      ENG_GAP   = 2'd2
   } eng_state_t;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
   parameter int CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [7:0] div_sel,
   output logic       tick
);

   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt_w
      $error("spi_clk_div: CNT_W must lie in 2..24");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;
   int               eff;

   // half period = 2^(d-1) core cycles, d clamped to 1..CNT_W
   always_comb begin
      if (div_sel == 8'd0)
         eff = 1;
      else if (int'(div_sel) > CNT_W)
         eff = CNT_W;
      else
         eff = int'(div_sel);
      half_m1 = CNT_W'((32'd1 << (eff - 1)) - 32'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == half_m1)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == half_m1);

   // R4: with a half period above one cycle, ticks never come back to back
   a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && half_m1 != '0) |=> (!tick || !$stable(div_sel)));

endmodule

// File: rtl/spi_tx_queue.sv
module spi_tx_queue #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic                         valid,
   output logic [$clog2(DEPTH+1)-1:0]   count
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_tx_queue: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic          push_ok;
   logic          pop_ok;

   assign push_ok = push && (count != CW'(DEPTH));
   assign pop_ok  = pop && (count != '0);
   assign valid   = (count != '0);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok)
         mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok)
            wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)
            rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_ctl_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         cpol,
   input  logic         cpha,
   input  logic         lsb_first,
   input  logic         tick,
   input  logic         q_valid,
   input  logic [W-1:0] q_data,
   output logic         q_pop,
   input  logic         miso,
   output logic         sclk,
   output logic         mosi,
   output logic         busy,
   output logic         rx_valid,
   output logic [W-1:0] rx_data,
   output logic         burst_start,
   output logic         burst_done
);

   localparam int EW = $clog2(2 * W) + 1;
   localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W);

   if (W < 2) begin : g_bad_w
      $error("spi_shift_engine: W must be at least 2");
   end

   eng_state_t    st;
   logic [W-1:0]  tx_sh;
   logic [W-1:0]  rx_sh;
   logic [W-1:0]  rx_nx;
   logic [W-1:0]  tx_nx;
   logic [EW-1:0] edge_cnt;
   logic [EW-1:0] edge_nx;
   logic          sclk_q;
   logic          smp;
   logic          shf;
   logic          load;

   assign edge_nx = edge_cnt + 1'b1;
   // odd edge numbers are leading edges; CPHA moves sampling to trailing
   assign smp = edge_nx[0] ^ cpha;
   assign shf = !smp && (edge_nx != EW'(1)) && (edge_nx != LAST_EDGE);

   assign rx_nx = lsb_first ? {miso, rx_sh[W-1:1]} : {rx_sh[W-2:0], miso};
   assign tx_nx = lsb_first ? {1'b0, tx_sh[W-1:1]} : {tx_sh[W-2:0], 1'b0};

   assign load = enable && q_valid &&
                 ((st == ENG_IDLE) || (st == ENG_GAP && tick));

   assign q_pop       = load;
   assign burst_start = load && (st == ENG_IDLE);
   assign burst_done  = enable && (st == ENG_GAP) && tick && !q_valid;
   assign rx_valid    = enable && (st == ENG_SHIFT) && tick && (edge_nx == LAST_EDGE);
   assign rx_data     = smp ? rx_nx : rx_sh;

   assign sclk = sclk_q;
   assign mosi = lsb_first ? tx_sh[0] : tx_sh[W-1];
   assign busy = (st != ENG_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ENG_IDLE;
         sclk_q   <= 1'b0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         edge_cnt <= '0;
      end else if (!enable) begin
         st     <= ENG_IDLE;
         sclk_q <= cpol;
      end else begin
         case (st)
            ENG_SHIFT: begin
               if (tick) begin
                  sclk_q   <= ~sclk_q;
                  edge_cnt <= edge_nx;
                  if (smp)
                     rx_sh <= rx_nx;
                  if (shf)
                     tx_sh <= tx_nx;
                  if (edge_nx == LAST_EDGE)
                     st <= ENG_GAP;
               end
            end
            ENG_GAP: begin
               if (tick)
                  st <= load ? ENG_SHIFT : ENG_IDLE;
            end
            default: begin
               sclk_q <= cpol;
               if (load)
                  st <= ENG_SHIFT;
            end
         endcase
         if (load) begin
            tx_sh    <= q_data;
            rx_sh    <= '0;
            edge_cnt <= '0;
         end
      end
   end

   // R3: after the sixteenth edge the clock is back at its rest level
   a_r3_rest_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (sclk == $past(cpol)));

   // R3: every tick while shifting moves the clock
   a_r3_tick_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && st == ENG_SHIFT && tick) |=> (sclk != $past(sclk)));

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
   import spi_ctl_pkg::*;
#(
   parameter int         TXQ_DEPTH = 8,
   parameter int         RX_REGS   = 8,
   parameter int         DIV_CNT_W = 16,
   parameter logic [7:0] DIV_RESET = 8'd2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [7:0] rd_addr,
   output logic [7:0] rd_data,
   output logic       sclk,
   output logic       mosi,
   output logic       ss_n,
   input  logic       miso,
   output logic       irq
);

   localparam int QCW   = $clog2(TXQ_DEPTH + 1);
   localparam int RX_IW = $clog2(RX_REGS);

   if (RX_REGS < 2 || RX_REGS > 16 || (RX_REGS & (RX_REGS - 1)) != 0) begin : g_bad_rx
      $error("spi_master_ctl: RX_REGS must be a power of two in 2..16");
   end

   logic [7:0]           cfg_q;
   logic [7:0]           div_q;
   logic                 ready_q;
   logic [RX_IW-1:0]     rx_idx;
   logic [RX_REGS*8-1:0] rx_flat;
   logic [7:0]           rx_off;
   logic [7:0]           status;

   logic                 q_push;
   logic                 q_pop;
   logic                 q_valid;
   logic [7:0]           q_dout;
   logic [QCW-1:0]       q_count;

   logic                 tick;
   logic                 eng_busy;
   logic                 rx_valid;
   logic [7:0]           rx_data;
   logic                 burst_start;
   logic                 burst_done;
   logic                 eng_sclk;

   logic                 stat_clr;

   assign q_push   = wr_en && (wr_addr == ADDR_TXQ) && !cfg_q[CFG_OFF];
   assign stat_clr = wr_en && (wr_addr == ADDR_STAT) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         div_q   <= DIV_RESET;
         ready_q <= 1'b0;
      end else begin
         if (wr_en && wr_addr == ADDR_CFG)
            cfg_q <= {1'b0, wr_data[6:0]};
         if (wr_en && wr_addr == ADDR_DIV)
            div_q <= wr_data;
         if (burst_done)
            ready_q <= 1'b1;
         else if (stat_clr)
            ready_q <= 1'b0;
      end
   end

   spi_tx_queue #(
      .DEPTH (TXQ_DEPTH),
      .W     (8)
   ) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   (wr_data),
      .pop   (q_pop),
      .dout  (q_dout),
      .valid (q_valid),
      .count (q_count)
   );

   spi_clk_div #(
      .CNT_W (DIV_CNT_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (eng_busy),
      .div_sel (div_q),
      .tick    (tick)
   );

   spi_shift_engine #(
      .W (8)
   ) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (!cfg_q[CFG_OFF]),
      .cpol        (cfg_q[CFG_CPOL]),
      .cpha        (cfg_q[CFG_CPHA]),
      .lsb_first   (cfg_q[CFG_LSB]),
      .tick        (tick),
      .q_valid     (q_valid),
      .q_data      (q_dout),
      .q_pop       (q_pop),
      .miso        (miso),
      .sclk        (eng_sclk),
      .mosi        (mosi),
      .busy        (eng_busy),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .burst_start (burst_start),
      .burst_done  (burst_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_idx <= '0;
      else if (burst_start)
         rx_idx <= '0;
      else if (rx_valid)
         rx_idx <= rx_idx + 1'b1;
   end

   for (genvar i = 0; i < RX_REGS; i++) begin : g_rx
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (rx_valid && rx_idx == RX_IW'(i))
            byte_q <= rx_data;
      end
      assign rx_flat[i*8 +: 8] = byte_q;
   end

   assign status = {5'b0,
                    (q_count >= QCW'(TXQ_DEPTH / 2)),
                    eng_busy,
                    ready_q};

   assign rx_off = rd_addr - ADDR_RXB;

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_CFG)
         rd_data = cfg_q;
      else if (rd_addr == ADDR_STAT)
         rd_data = status;
      else if (rd_addr == ADDR_DIV)
         rd_data = div_q;
      else if (rd_addr >= ADDR_RXB && rx_off < 8'(RX_REGS))
         rd_data = rx_flat[rx_off[RX_IW-1:0]*8 +: 8];
   end

   assign sclk = eng_sclk;
   assign ss_n = cfg_q[CFG_OFF] ? 1'b1 :
                 cfg_q[CFG_MAN] ? cfg_q[CFG_SSV] : !eng_busy;
   assign irq  = cfg_q[CFG_IEN] & ready_q;

   // R6: in automatic mode the slave is selected whenever the clock moves
   a_r6_ss_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(eng_busy) && eng_busy && sclk != $past(sclk) &&
       !cfg_q[CFG_MAN] && !cfg_q[CFG_OFF]) |-> !ss_n);

   // R8: a transmit write while disabled leaves the queue untouched
   a_r8_tx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_TXQ && cfg_q[CFG_OFF]) |=> (q_count == $past(q_count)));

   // R11: a clearing write without a coinciding burst end drops the flag
   a_r11_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !burst_done) |=> !status[0]);

endmodule

// File: tb/sim_spi_master_ctl.sv
module sim_spi_master_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       sclk;
   logic       mosi;
   logic       ss_n;
   logic       miso;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   logic         cur_cpol = 1'b0;
   logic         cur_cpha = 1'b0;
   logic [255:0] cap_bits = '0;
   logic [255:0] slv_bits = '0;
   logic [7:0]   cap_cnt = '0;
   int           edges = 0;
   int           ss_falls = 0;
   int           cyc = 0;
   int           lead_n = 0;
   int           lead_c0 = 0;
   int           lead_c1 = 0;

   always #5 clk = ~clk;

   spi_master_ctl u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .sclk    (sclk),
      .mosi    (mosi),
      .ss_n    (ss_n),
      .miso    (miso),
      .irq     (irq)
   );

   // bench slave: presents the next bit, captures MOSI on sampling edges
   assign miso = slv_bits[cap_cnt];

   always @(posedge clk) cyc++;

   always @(sclk) begin
      if (rst_n) begin
         edges++;
         if (sclk != cur_cpol) begin
            if (lead_n == 0) lead_c0 = cyc;
            if (lead_n == 1) lead_c1 = cyc;
            lead_n++;
         end
         if ((sclk != cur_cpol) ^ cur_cpha) begin
            cap_bits[cap_cnt] = mosi;
            cap_cnt = cap_cnt + 8'd1;
         end
      end
   end

   always @(negedge ss_n) if (rst_n) ss_falls++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic clear_obs();
      cap_bits = '0; cap_cnt = '0; edges = 0; ss_falls = 0; lead_n = 0;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      repeat (4) @(negedge clk);
      for (int t = 0; t < 20000; t++) begin
         rd(8'h01, s);
         if (!s[1]) break;
      end
   endtask

   function automatic logic [7:0] cap_byte(input int j, input logic lsb);
      logic [7:0] b;
      for (int k = 0; k < 8; k++)
         if (lsb) b[k] = cap_bits[8*j+k];
         else     b[7-k] = cap_bits[8*j+k];
      return b;
   endfunction

   task automatic load_slave(input int j, input logic [7:0] b, input logic lsb);
      for (int k = 0; k < 8; k++)
         slv_bits[8*j+k] = lsb ? b[k] : b[7-k];
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk(ss_n == 1'b1, "R1 ss_n", int'(ss_n), 1);
      chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);
      rd(8'h00, d); chk(d == 8'h00, "R1 cfg", d, 0);
      rd(8'h01, d); chk(d == 8'h00, "R1 status", d, 0);
      rd(8'h02, d); chk(d == 8'h02, "R1/R2 divider", d, 2);
      rd(8'h33, d); chk(d == 8'h00, "R2 unmapped", d, 0);
      rd(8'h08, d); chk(d == 8'h00, "R2 tx write-only", d, 0);
   endtask

   task automatic run_burst(input string tag, input logic cp, input logic ph,
                            input logic lsb, input int n,
                            input logic [63:0] txb, input logic [63:0] sxb);
      logic [7:0] d;
      cur_cpol = cp; cur_cpha = ph;
      wr(8'h00, {3'b000, lsb, ph, cp, 2'b00});
      repeat (3) @(negedge clk);
      chk(sclk == cp, {tag, " R3 rest level"}, int'(sclk), int'(cp));
      clear_obs();
      slv_bits = '0;
      for (int j = 0; j < n; j++) load_slave(j, sxb[8*j +: 8], lsb);
      for (int j = 0; j < n; j++) wr(8'h08, txb[8*j +: 8]);
      wait_idle();
      chk(edges == 16*n, {tag, " R3 edge count"}, edges, 16*n);
      chk(ss_falls == 1, {tag, " R6 one select"}, ss_falls, 1);
      chk(ss_n == 1'b1, {tag, " R6 released"}, int'(ss_n), 1);
      for (int j = 0; j < n; j++) begin
         chk(cap_byte(j, lsb) == txb[8*j +: 8], {tag, " R5 mosi byte"},
             cap_byte(j, lsb), txb[8*j +: 8]);
         rd(8'h10 + 8'(j), d);
         chk(d == sxb[8*j +: 8], {tag, " R5/R10 rx byte"}, d, sxb[8*j +: 8]);
      end
      rd(8'h01, d);
      chk(d[0] == 1'b1, {tag, " R11 ready"}, d, 1);
      wr(8'h01, 8'h01);
      rd(8'h01, d);
      chk(d == 8'h00, {tag, " R11 cleared"}, d, 0);
   endtask

   task automatic t_period(input logic [7:0] dv, input int exp_cyc);
      cur_cpol = 1'b0; cur_cpha = 1'b0;
      wr(8'h02, dv);
      wr(8'h00, 8'h00);
      repeat (3) @(negedge clk);
      clear_obs();
      wr(8'h08, 8'h5A);
      wait_idle();
      chk(lead_c1 - lead_c0 == exp_cyc, "R4 sclk period", lead_c1 - lead_c0, exp_cyc);
      wr(8'h01, 8'h01);
   endtask

   task automatic t_manual();
      wr(8'h00, 8'h60);
      repeat (2) @(negedge clk);
      chk(ss_n == 1'b1, "R7 manual high", int'(ss_n), 1);
      wr(8'h00, 8'h20);
      repeat (2) @(negedge clk);
      chk(ss_n == 1'b0, "R7 manual low", int'(ss_n), 0);
      wr(8'h00, 8'h00);
      repeat (2) @(negedge clk);
      chk(ss_n == 1'b1, "R6 auto idle high", int'(ss_n), 1);
   endtask

   task automatic t_disabled();
      logic [7:0] d;
      cur_cpol = 1'b1;
      wr(8'h00, 8'h05);
      repeat (3) @(negedge clk);
      chk(sclk == 1'b1, "R8 sclk at cpol", int'(sclk), 1);
      chk(ss_n == 1'b1, "R8 ss_n high", int'(ss_n), 1);
      clear_obs();
      wr(8'h08, 8'hAA);
      repeat (60) @(negedge clk);
      chk(edges == 0, "R8 no clocking", edges, 0);
      rd(8'h01, d);
      chk(d == 8'h00, "R8 not busy", d, 0);
      cur_cpol = 1'b0;
      wr(8'h00, 8'h00);
      repeat (60) @(negedge clk);
      clear_obs();
      repeat (60) @(negedge clk);
      rd(8'h01, d);
      chk(d == 8'h00, "R8 write was dropped", d, 0);
      chk(ss_falls == 0 && edges == 0, "R8 nothing sent", edges, 0);
   endtask

   task automatic t_queue();
      logic [7:0] d;
      cur_cpol = 1'b0; cur_cpha = 1'b0;
      wr(8'h02, 8'd4);
      wr(8'h00, 8'h00);
      repeat (3) @(negedge clk);
      clear_obs();
      slv_bits = '0;
      for (int j = 0; j < 9; j++) load_slave(j, 8'hC0 + 8'(j), 1'b0);
      for (int j = 0; j < 4; j++) wr(8'h08, 8'h30 + 8'(j));
      rd(8'h01, d);
      chk(d[2] == 1'b0, "R9 three queued below half", d, 8'h02);
      wr(8'h08, 8'h34);
      rd(8'h01, d);
      chk(d[2] == 1'b1, "R9 four queued is half", d, 8'h06);
      for (int j = 5; j < 10; j++) wr(8'h08, 8'h30 + 8'(j));
      wait_idle();
      chk(edges == 144, "R9 full-queue write dropped", edges, 144);
      chk(cap_byte(8, 1'b0) == 8'h38, "R9 last sent byte", cap_byte(8, 1'b0), 8'h38);
      rd(8'h10, d); chk(d == 8'hC8, "R10 wrapped to index 0", d, 8'hC8);
      rd(8'h11, d); chk(d == 8'hC1, "R10 index 1", d, 8'hC1);
      rd(8'h17, d); chk(d == 8'hC7, "R10 index 7", d, 8'hC7);
      wr(8'h01, 8'h01);
      wr(8'h02, 8'd2);
      run_burst("restart", 1'b0, 1'b0, 1'b0, 1, 64'h6B, 64'h9D);
      rd(8'h11, d); chk(d == 8'hC1, "R10 restart keeps index 1", d, 8'hC1);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      cur_cpol = 1'b0; cur_cpha = 1'b0;
      wr(8'h00, 8'h00);
      wr(8'h08, 8'h11);
      wait_idle();
      @(negedge clk);
      chk(irq == 1'b0, "R12 masked", int'(irq), 0);
      wr(8'h00, 8'h02);
      @(negedge clk);
      chk(irq == 1'b1, "R12 raised", int'(irq), 1);
      wr(8'h01, 8'h00);
      rd(8'h01, d);
      chk(d[0] == 1'b1, "R11 write 0 keeps flag", d, 1);
      wr(8'h01, 8'h01);
      @(negedge clk);
      chk(irq == 1'b0, "R12 dropped after clear", int'(irq), 0);
      wr(8'h00, 8'h00);
   endtask

   task automatic finish_up();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      run_burst("mode0 msb", 1'b0, 1'b0, 1'b0, 2, 64'hA53C, 64'h0FE1);
      run_burst("mode3 lsb", 1'b1, 1'b1, 1'b1, 2, 64'h81C6, 64'h4D72);
      run_burst("mode1 msb", 1'b0, 1'b1, 1'b0, 3, 64'h19B4E7, 64'hF0285C);
      run_burst("mode2 lsb", 1'b1, 1'b0, 1'b1, 1, 64'h2D, 64'hB3);
      t_period(8'd3, 8);
      t_period(8'd0, 2);
      wr(8'h02, 8'd2);
      t_manual();
      t_disabled();
      t_queue();
      t_irq();
      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_up();
   end

endmodule